// File: doc/BRIEF.md
# Channel-Status and User-Bit Serial Output Timer

This block sits after a digital audio interface decoder and drives the dedicated serial pins that carry the per-sample side information: the channel-status bit, the user bit, a block marker, an error flag and a flag that combines validity with error. The decoder hands over one set of bits per subframe on a strobe. The block holds the latest set and puts it on the pins in step with the frame sync of the audio serial port. The block runs on the port's bit clock, and each audio sample lasts a fixed number of bit clocks.

In the left-justified and right-justified style formats, the channel-status bit, the user bit and the block marker are put out one bit clock ahead of the frame-sync transition, so that an external device can latch them on that transition. In I2S-style formats the same three outputs change on the transition itself. The error and validity-or-error flags always change on the transition. The block marker follows a 192-frame channel-status block. It is high for the first 32 frames (64 samples) and low for the other 160 frames. A block-start flag from the decoder brings its position back to the start of the block.

A port-reset mode input clears the block and holds every output low. When the mode ends, the block starts again as it does after a power-up reset.

Top module: `csu_out_timing`

## Requirements
- R1: With `i2s_sel`=0, `cs_out`, `user_out` and `blk_mark` take their new values one bit clock before the clock at which a frame-sync transition is seen, and hold them for the rest of the sample. Either direction of `fsync` change is a transition, and a sample lasts 32 bit clocks.
- R2: With `i2s_sel`=1, `cs_out`, `user_out` and `blk_mark` keep their old values up to the transition and take their new values at the clock that sees the transition.
- R3: `err_out` changes only at the clock that sees a frame-sync transition, in both modes.
- R4: `verr_out` equals the OR of `sub_valid` and `sub_err` for the sample that `err_out` presents.
- R5: A sample counter advances once per sample and wraps after 384 samples (192 frames). `blk_mark` is 1 while the counter is below 64 and 0 otherwise.
- R6: A sample captured with `sub_bstart`=1 sets the sample counter to 0 when it is presented, so `blk_mark` becomes 1.
- R7: After a reset, and while `port_rst`=1, all five outputs are 0. Strobes and `fsync` changes during `port_rst` have no effect.
- R8: The outputs are loaded at most once per sample, from the most recent `sub_stb` capture. If the early load point was missed (for example, the first sample after a reset), the load happens at the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_rst | input | 1 | Port reset mode: clears the block and forces outputs low |
| fsync | input | 1 | Audio port frame sync; every level change starts a sample |
| i2s_sel | input | 1 | 1 = I2S-style timing, 0 = lead-by-one timing |
| sub_stb | input | 1 | Capture strobe for one subframe's bits |
| sub_cs | input | 1 | Channel-status bit of the subframe |
| sub_user | input | 1 | User bit of the subframe |
| sub_valid | input | 1 | Validity bit of the subframe |
| sub_err | input | 1 | Decoder error (parity, coding or lock) for the subframe |
| sub_bstart | input | 1 | Subframe begins a channel-status block |
| cs_out | output | 1 | Serial channel-status bit |
| user_out | output | 1 | Serial user bit |
| blk_mark | output | 1 | High for the first 32 frames of each block |
| err_out | output | 1 | Error flag |
| verr_out | output | 1 | Validity OR error flag |

## Verification
Two situations are hard to reach from the ports. The first is the hand-over between modes: a sample whose early load already happened must not be loaded a second time when I2S timing takes over at the next transition. The bench walks a vector table that switches `i2s_sel` in both directions between samples and checks the pins just before and just after each transition. The second is the wrap of the 384-sample counter with no new block-start flag. A long directed run crosses that wrap and checks the marker on every sample, and a late block-start flag then shows that the counter goes back to zero in the middle of a block.

// File: rtl/csu_pkg.sv
package csu_pkg;

   typedef struct packed {
      logic cs;
      logic user;
      logic valid;
      logic err;
      logic bstart;
   } csu_bits_t;

   localparam int unsigned CSU_SLOT_BITS_DEF  = 32;
   localparam int unsigned CSU_BLOCK_FRM_DEF  = 192;
   localparam int unsigned CSU_MARK_FRM_DEF   = 32;
   localparam int unsigned CSU_CH_PER_FRM_DEF = 2;

endpackage

// File: rtl/csu_slot_timer.sv
module csu_slot_timer #(
   parameter int unsigned SLOT_BITS = 32,
   parameter int unsigned LEAD      = 1
) (
   input  logic sclk,
   input  logic rst_n,
   input  logic clr,
   input  logic fsync,
   input  logic i2s_sel,
   output logic edge_o,
   output logic load_o
);
   localparam int unsigned CNT_W = $clog2(SLOT_BITS);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_BITS - 1);

   logic             fs_q;
   logic             synced_q;
   logic             done_q;
   logic [CNT_W-1:0] cnt_q;
   logic             early;

   assign edge_o = fsync ^ fs_q;

   generate
      if (LEAD == 0) begin : g_no_lead
         assign early = 1'b0;
      end else begin : g_lead
         localparam logic [CNT_W-1:0] PRE_CNT = CNT_W'(SLOT_BITS - 1 - LEAD);
         assign early = synced_q & ~i2s_sel & ~done_q & (cnt_q == PRE_CNT);
      end
   endgenerate

   assign load_o = early | (edge_o & ~done_q);

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q     <= 1'b0;
         synced_q <= 1'b0;
         done_q   <= 1'b0;
         cnt_q    <= '0;
      end else if (clr) begin
         fs_q     <= 1'b0;
         synced_q <= 1'b0;
         done_q   <= 1'b0;
         cnt_q    <= '0;
      end else begin
         fs_q <= fsync;
         if (edge_o) begin
            cnt_q    <= '0;
            synced_q <= 1'b1;
            done_q   <= 1'b0;
         end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (early) done_q <= 1'b1;
         end
      end
   end

   AST_LOAD_ONCE: assert property (@(posedge sclk) disable iff (!rst_n)
      (load_o && !edge_o && !clr) |=> (!load_o || edge_o)); // R8

endmodule

// File: rtl/csu_bit_capture.sv
module csu_bit_capture
   import csu_pkg::*;
(
   input  logic      sclk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      stb_i,
   input  csu_bits_t bits_i,
   input  logic      consume_i,
   output csu_bits_t hold_o
);
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         hold_o <= '0;
      end else if (clr) begin
         hold_o <= '0;
      end else if (stb_i) begin
         hold_o <= bits_i;
      end else if (consume_i) begin
         hold_o.bstart <= 1'b0;
      end
   end

endmodule

// File: rtl/csu_block_track.sv
module csu_block_track #(
   parameter int unsigned BLOCK_FRAMES = 192,
   parameter int unsigned MARK_FRAMES  = 32,
   parameter int unsigned CH_PER_FRAME = 2
) (
   input  logic sclk,
   input  logic rst_n,
   input  logic clr,
   input  logic load_i,
   input  logic bstart_i,
   output logic mark_o
);
   localparam int unsigned SAMPLES = BLOCK_FRAMES * CH_PER_FRAME;
   localparam int unsigned IDX_W   = $clog2(SAMPLES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;
   logic             mark_hit;

   always_comb begin
      if (bstart_i)              idx_nxt = '0;
      else if (idx_q == LAST_IDX) idx_nxt = '0;
      else                        idx_nxt = idx_q + 1'b1;
   end

   generate
      if (MARK_FRAMES == 0) begin : g_mark_none
         assign mark_hit = 1'b0;
      end else if (MARK_FRAMES >= BLOCK_FRAMES) begin : g_mark_all
         assign mark_hit = 1'b1;
      end else begin : g_mark_cmp
         localparam logic [IDX_W-1:0] MARK_SAMPLES = IDX_W'(MARK_FRAMES * CH_PER_FRAME);
         assign mark_hit = (idx_nxt < MARK_SAMPLES);
      end
   endgenerate

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         mark_o <= 1'b0;
      end else if (clr) begin
         idx_q  <= '0;
         mark_o <= 1'b0;
      end else if (load_i) begin
         idx_q  <= idx_nxt;
         mark_o <= mark_hit;
      end
   end

   generate
      if (MARK_FRAMES > 0) begin : g_ast_mark
         AST_BSTART_MARK: assert property (@(posedge sclk) disable iff (!rst_n)
            (load_i && bstart_i && !clr) |=> mark_o); // R6
      end
   endgenerate

endmodule

// File: rtl/csu_out_timing.sv
module csu_out_timing
   import csu_pkg::*;
#(
   parameter int unsigned SLOT_BITS    = CSU_SLOT_BITS_DEF,
   parameter int unsigned LEAD         = 1,
   parameter int unsigned BLOCK_FRAMES = CSU_BLOCK_FRM_DEF,
   parameter int unsigned MARK_FRAMES  = CSU_MARK_FRM_DEF,
   parameter int unsigned CH_PER_FRAME = CSU_CH_PER_FRM_DEF
) (
   input  logic sclk,
   input  logic rst_n,
   input  logic port_rst,
   input  logic fsync,
   input  logic i2s_sel,
   input  logic sub_stb,
   input  logic sub_cs,
   input  logic sub_user,
   input  logic sub_valid,
   input  logic sub_err,
   input  logic sub_bstart,
   output logic cs_out,
   output logic user_out,
   output logic blk_mark,
   output logic err_out,
   output logic verr_out
);
   generate
      if (SLOT_BITS < LEAD + 2) begin : g_bad_slot
         $error("SLOT_BITS must exceed LEAD by at least two");
      end
      if (CH_PER_FRAME < 1) begin : g_bad_ch
         $error("CH_PER_FRAME must be at least one");
      end
      if (MARK_FRAMES > BLOCK_FRAMES) begin : g_bad_mark
         $error("MARK_FRAMES cannot exceed BLOCK_FRAMES");
      end
   endgenerate

   csu_bits_t in_bits;
   csu_bits_t hold;
   logic      edge_w;
   logic      load_w;

   assign in_bits = '{cs: sub_cs, user: sub_user, valid: sub_valid,
                      err: sub_err, bstart: sub_bstart};

   csu_slot_timer #(
      .SLOT_BITS (SLOT_BITS),
      .LEAD      (LEAD)
   ) timer_i (
      .sclk    (sclk),
      .rst_n   (rst_n),
      .clr     (port_rst),
      .fsync   (fsync),
      .i2s_sel (i2s_sel),
      .edge_o  (edge_w),
      .load_o  (load_w)
   );

   csu_bit_capture capture_i (
      .sclk      (sclk),
      .rst_n     (rst_n),
      .clr       (port_rst),
      .stb_i     (sub_stb),
      .bits_i    (in_bits),
      .consume_i (load_w),
      .hold_o    (hold)
   );

   csu_block_track #(
      .BLOCK_FRAMES (BLOCK_FRAMES),
      .MARK_FRAMES  (MARK_FRAMES),
      .CH_PER_FRAME (CH_PER_FRAME)
   ) track_i (
      .sclk     (sclk),
      .rst_n    (rst_n),
      .clr      (port_rst),
      .load_i   (load_w),
      .bstart_i (hold.bstart),
      .mark_o   (blk_mark)
   );

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         cs_out   <= 1'b0;
         user_out <= 1'b0;
         err_out  <= 1'b0;
         verr_out <= 1'b0;
      end else if (port_rst) begin
         cs_out   <= 1'b0;
         user_out <= 1'b0;
         err_out  <= 1'b0;
         verr_out <= 1'b0;
      end else begin
         if (load_w) begin
            cs_out   <= hold.cs;
            user_out <= hold.user;
         end
         if (edge_w) begin
            err_out  <= hold.err;
            verr_out <= hold.valid | hold.err;
         end
      end
   end

   AST_CU_ON_LOAD: assert property (@(posedge sclk) disable iff (!rst_n)
      !$stable(cs_out) |-> ($past(load_w) || $past(port_rst))); // R1

   AST_ERR_ON_EDGE: assert property (@(posedge sclk) disable iff (!rst_n)
      !$stable(err_out) |-> ($past(edge_w) || $past(port_rst))); // R3

   AST_VERR_COVERS: assert property (@(posedge sclk) disable iff (!rst_n)
      err_out |-> verr_out); // R4

   AST_PORT_RST_LOW: assert property (@(posedge sclk) disable iff (!rst_n)
      $past(port_rst) |-> !(cs_out || user_out || blk_mark || err_out || verr_out)); // R7

endmodule

// File: tb/csu_out_timing_tb.sv
module csu_out_timing_tb_top;
   logic sclk = 1'b0;
   logic rst_n = 1'b0;
   logic port_rst = 1'b0;
   logic fsync = 1'b0;
   logic i2s_sel = 1'b0;
   logic sub_stb = 1'b0;
   logic sub_cs = 1'b0, sub_user = 1'b0, sub_valid = 1'b0, sub_err = 1'b0, sub_bstart = 1'b0;
   logic cs_out, user_out, blk_mark, err_out, verr_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 sclk = ~sclk;

   csu_out_timing dut_i (
      .sclk(sclk), .rst_n(rst_n), .port_rst(port_rst), .fsync(fsync), .i2s_sel(i2s_sel),
      .sub_stb(sub_stb), .sub_cs(sub_cs), .sub_user(sub_user), .sub_valid(sub_valid),
      .sub_err(sub_err), .sub_bstart(sub_bstart),
      .cs_out(cs_out), .user_out(user_out), .blk_mark(blk_mark),
      .err_out(err_out), .verr_out(verr_out)
   );

   // vector fields: {i2s, cs, user, valid, err, bstart, expected verr}
   localparam logic [9:0][6:0] VEC = {
      7'b1_0000_0_0,
      7'b0_1010_0_1,
      7'b0_0101_0_1,
      7'b1_1100_0_0,
      7'b1_0111_0_1,
      7'b1_1000_0_0,
      7'b0_0001_0_1,
      7'b0_1110_0_1,
      7'b0_0100_0_0,
      7'b0_1000_1_0
   };

   // bench model
   logic pd_c = 0, pd_u = 0, pd_e = 0, pd_b = 0, pd_xv = 0;
   logic sh_c = 0, sh_u = 0, sh_e = 0, sh_xv = 0;
   logic prev_i2s = 0;
   int   m_idx = 0;
   bit   blk_known = 0;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic model_reset();
      pd_c = 0; pd_u = 0; pd_e = 0; pd_b = 0; pd_xv = 0;
      sh_c = 0; sh_u = 0; sh_e = 0; sh_xv = 0;
      m_idx = 0; blk_known = 0; prev_i2s = 0;
   endtask

   task automatic run_sample(input logic md, input logic c, input logic u, input logic v,
                             input logic e, input logic b, input logic xv, input bit chk_on);
      for (int j = 0; j < 32; j++) begin
         @(negedge sclk);
         if (j == 0) begin
            if (chk_on) begin
               if (prev_i2s) begin
                  chk("R2 cs held before transition", cs_out, sh_c);
                  chk("R2 user held before transition", user_out, sh_u);
               end else begin
                  chk("R1 cs one clock early", cs_out, pd_c);
                  chk("R1 user one clock early", user_out, pd_u);
               end
               chk("R3 err unchanged before transition", err_out, sh_e);
            end
            fsync   = ~fsync;
            i2s_sel = md;
         end
         if (j == 1) begin
            sh_c = pd_c; sh_u = pd_u; sh_e = pd_e; sh_xv = pd_xv;
            if (pd_b) begin
               m_idx = 0; blk_known = 1;
            end else begin
               m_idx = (m_idx + 1) % 384;
            end
            if (chk_on) begin
               chk(prev_i2s ? "R2 cs at transition" : "R1 cs after transition", cs_out, sh_c);
               chk(prev_i2s ? "R2 user at transition" : "R1 user after transition", user_out, sh_u);
               chk("R3 err at transition", err_out, sh_e);
               chk("R4 verr value", verr_out, sh_xv);
               if (blk_known)
                  chk(pd_b ? "R6 marker after block start" : "R5 marker position", blk_mark,
                      (m_idx < 64) ? 1'b1 : 1'b0);
            end
         end
         if (j == 2) begin
            sub_cs = c; sub_user = u; sub_valid = v; sub_err = e; sub_bstart = b;
            sub_stb = 1'b1;
            pd_c = c; pd_u = u; pd_e = e; pd_b = b; pd_xv = xv;
         end
         if (j == 3) sub_stb = 1'b0;
         if (j == 31 && chk_on) chk("R8 cs loaded once per sample", cs_out, sh_c);
      end
      prev_i2s = md;
   endtask

   initial begin
      repeat (3) @(negedge sclk);
      rst_n = 1'b1;
      @(negedge sclk);
      chk("R7 reset cs", cs_out, 1'b0);
      chk("R7 reset user", user_out, 1'b0);
      chk("R7 reset marker", blk_mark, 1'b0);
      chk("R7 reset err", err_out, 1'b0);
      chk("R7 reset verr", verr_out, 1'b0);

      run_sample(1'b0, 0, 0, 0, 0, 0, 0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         logic [6:0] vv;
         vv = VEC[i];
         run_sample(vv[6], vv[5], vv[4], vv[3], vv[2], vv[1], vv[0], 1'b1);
      end

      // block walk: start, wrap at 384 samples, then a late resync
      run_sample(1'b0, 1, 1, 0, 0, 1, 0, 1'b1);
      for (int k = 0; k < 460; k++) begin
         logic mk, ck, uk, ek, bk;
         mk = ((k / 50) % 2) == 1;
         ck = k[0];
         uk = k[1];
         ek = (k % 7) == 3;
         bk = (k == 390);
         run_sample(mk, ck, uk, 1'b0, ek, bk, ek, 1'b1);
      end

      // port reset mode: outputs low, stimulus ignored
      @(negedge sclk);
      port_rst = 1'b1;
      fsync = 1'b0;
      for (int j = 0; j < 6; j++) begin
         @(negedge sclk);
         sub_cs = 1; sub_user = 1; sub_valid = 1; sub_err = 1; sub_bstart = 1;
         sub_stb = (j == 2);
      end
      @(negedge sclk);
      chk("R7 port reset cs", cs_out, 1'b0);
      chk("R7 port reset user", user_out, 1'b0);
      chk("R7 port reset marker", blk_mark, 1'b0);
      chk("R7 port reset err", err_out, 1'b0);
      chk("R7 port reset verr", verr_out, 1'b0);
      sub_stb = 1'b0;
      sub_cs = 0; sub_user = 0; sub_valid = 0; sub_err = 0; sub_bstart = 0;
      port_rst = 1'b0;
      model_reset();
      run_sample(1'b0, 0, 0, 0, 0, 0, 0, 1'b0);
      run_sample(1'b0, 1, 0, 0, 0, 1, 0, 1'b1);
      run_sample(1'b1, 0, 1, 1, 0, 0, 1, 1'b1);
      run_sample(1'b0, 1, 1, 0, 1, 0, 1, 1'b1);
      run_sample(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge sclk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule